// File: doc/BRIEF.md
# Configuration PROM CRC checker

This block validates a configuration PROM image held in a word-addressed store. It reads the image one 16-bit word at a time through a simple read port and runs an 8-bit CRC over it, one byte per clock. The image length is not known in advance. The checker first assumes the short length. If the stored CRC does not match, it reads the image again from word zero using the long length of 220 words. The result is a pass/fail flag, a flag that shows which length was accepted, and the revision byte taken from the final word.

The CRC uses the polynomial x^8+x^7+x^6+x^4+x^2+1 in reflected, LSB-first form, which gives the constant 0xAB. Each word feeds its low byte first and its high byte second. The final word of the image is different: its low byte is the revision, and it is the only byte of that word fed to the CRC. Its high byte holds the expected CRC.

A single-cycle start pulse begins a check. A single-cycle done pulse ends it, and the result outputs then hold until the next accepted start.

Top module: `cfgprom_crc_chk`

## Requirements
- R1: The CRC register is set to 0xFF at the start of each length attempt. Each byte updates it LSB-first with the reflected polynomial 0xAB, so byte 0x01 on a zero register gives 0xF7. The register is XORed with 0xFF before the compare.
- R2: Every word except the final one feeds the CRC with its low byte (bits 7:0) and then its high byte (bits 15:8).
- R3: The final word feeds only its low byte. Its bits 15:8 are the expected CRC. Its bits 7:0 are reported on `revision`.
- R4: The short length (SHORT_WORDS, default 64) is tried first. If it matches, `valid`=1 and `size_long`=0, and no address at or above SHORT_WORDS is read.
- R5: If the short attempt fails, the image is re-read from address 0 as LONG_WORDS (220) words. If that matches, `valid`=1 and `size_long`=1.
- R6: If both attempts fail, `valid`=0, `size_long`=1, and `revision` shows the low byte of word LONG_WORDS-1.
- R7: A read is issued by raising `rd_en` with `rd_addr`, and `rd_data` is taken on the following cycle. Addresses run from 0 in order. No address at or beyond the length being tried is issued.
- R8: `done` is high for exactly one cycle per check. `valid`, `size_long` and `revision` change only with `done` or one cycle after an accepted start, and otherwise hold.
- R9: A start pulse that arrives while a check is running is ignored. The running check completes with an unchanged result and a single `done` pulse.
- R10: While reset is asserted, and right after it is released, `done`, `valid`, `size_long` and `rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle pulse that begins a check when idle |
| rd_en | output | 1 | Word read request |
| rd_addr | output | ADDR_W | Word address of the read request |
| rd_data | input | 16 | Word returned one cycle after `rd_en` |
| done | output | 1 | One-cycle completion pulse |
| valid | output | 1 | CRC matched for the reported length |
| size_long | output | 1 | 1 when the long length was the last one tried |
| revision | output | 8 | Low byte of the final word of the last length tried |

## Verification
The assertions take two things for granted. First, the store answers every read with its word on the cycle after `rd_en`. Second, the image does not change while a check is running. The bench's memory model registers each read on the request edge and loads each image only between checks, so both assumptions hold. Stray starts are pulsed only at points where the block is either idle or visibly busy, so each start has a known intended effect. Images are built so that the short attempt is forced to match or forced to mismatch, as each case requires.

// File: rtl/cfgprom_pkg.sv
package cfgprom_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CRC_POLY_REFL = 8'hAB;
  localparam logic [BYTE_W-1:0] CRC_SEED      = 8'hFF;
  localparam logic [BYTE_W-1:0] CRC_XOROUT    = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOW,
    ST_HIGH,
    ST_FINAL
  } chk_state_e;
endpackage

// File: rtl/cfgprom_crc_byte.sv
module cfgprom_crc_byte
  import cfgprom_pkg::*;
#(
  parameter logic [BYTE_W-1:0] POLY = CRC_POLY_REFL
) (
  input  logic [BYTE_W-1:0] crc_in,
  input  logic [BYTE_W-1:0] data_in,
  output logic [BYTE_W-1:0] crc_out
);
  logic [BYTE_W-1:0] stage [0:BYTE_W];

  assign stage[0] = crc_in ^ data_in;

  for (genvar g = 0; g < BYTE_W; g++) begin : g_bit
    assign stage[g+1] = stage[g][0] ? ((stage[g] >> 1) ^ POLY) : (stage[g] >> 1);
  end

  assign crc_out = stage[BYTE_W];
endmodule

// File: rtl/cfgprom_crc_reg.sv
module cfgprom_crc_reg
  import cfgprom_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_en,
  input  logic              feed_en,
  input  logic [BYTE_W-1:0] feed_byte,
  output logic [BYTE_W-1:0] crc_q
);
  logic [BYTE_W-1:0] crc_nxt;
  logic [BYTE_W-1:0] crc_d;

  cfgprom_crc_byte #(.POLY(CRC_POLY_REFL)) u_step (
    .crc_in  (crc_q),
    .data_in (feed_byte),
    .crc_out (crc_nxt)
  );

  always_comb begin
    crc_d = crc_q;
    if (seed_en)      crc_d = CRC_SEED;
    else if (feed_en) crc_d = crc_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else if (seed_en || feed_en) crc_q <= crc_d;
  end

  AST_SEED_FEED_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(seed_en && feed_en)); // R1
endmodule

// File: rtl/cfgprom_seq.sv
module cfgprom_seq
  import cfgprom_pkg::*;
#(
  parameter int SHORT_WORDS = 64,
  parameter int LONG_WORDS  = 220,
  parameter int ADDR_W      = $clog2(LONG_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  input  logic [BYTE_W-1:0] crc_q,
  output logic              seed_en,
  output logic              feed_en,
  output logic [BYTE_W-1:0] feed_byte,
  output logic              done,
  output logic              valid,
  output logic              size_long,
  output logic [BYTE_W-1:0] revision
);
  localparam logic [ADDR_W-1:0] LAST_SHORT = ADDR_W'(SHORT_WORDS - 1);
  localparam logic [ADDR_W-1:0] LAST_LONG  = ADDR_W'(LONG_WORDS - 1);

  chk_state_e        state_q, state_d;
  logic [ADDR_W-1:0] idx_q, idx_d;
  logic              long_q, long_d;
  logic [BYTE_W-1:0] hi_q, hi_d;
  logic [BYTE_W-1:0] exp_q, exp_d;
  logic [BYTE_W-1:0] rev_q, rev_d;
  logic              done_q, done_d;
  logic              valid_q, valid_d;
  logic              slong_q, slong_d;
  logic [BYTE_W-1:0] revo_q, revo_d;
  logic [ADDR_W-1:0] last_idx;
  logic              crc_match;

  assign last_idx  = long_q ? LAST_LONG : LAST_SHORT;
  assign crc_match = ((crc_q ^ CRC_XOROUT) == exp_q);

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    long_d    = long_q;
    hi_d      = hi_q;
    exp_d     = exp_q;
    rev_d     = rev_q;
    done_d    = 1'b0;
    valid_d   = valid_q;
    slong_d   = slong_q;
    revo_d    = revo_q;
    rd_en     = 1'b0;
    rd_addr   = idx_q;
    seed_en   = 1'b0;
    feed_en   = 1'b0;
    feed_byte = rd_data[BYTE_W-1:0];
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          seed_en = 1'b1;
          idx_d   = '0;
          long_d  = 1'b0;
          valid_d = 1'b0;
          slong_d = 1'b0;
          revo_d  = '0;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        rd_en   = 1'b1;
        state_d = ST_LOW;
      end
      ST_LOW: begin
        feed_en = 1'b1;
        hi_d    = rd_data[WORD_W-1:BYTE_W];
        if (idx_q == last_idx) begin
          exp_d   = rd_data[WORD_W-1:BYTE_W];
          rev_d   = rd_data[BYTE_W-1:0];
          state_d = ST_FINAL;
        end else begin
          state_d = ST_HIGH;
        end
      end
      ST_HIGH: begin
        feed_en   = 1'b1;
        feed_byte = hi_q;
        rd_en     = 1'b1;
        rd_addr   = idx_q + 1'b1;
        idx_d     = idx_q + 1'b1;
        state_d   = ST_LOW;
      end
      ST_FINAL: begin
        if (crc_match || long_q) begin
          done_d  = 1'b1;
          valid_d = crc_match;
          slong_d = long_q;
          revo_d  = rev_q;
          state_d = ST_IDLE;
        end else begin
          seed_en = 1'b1;
          idx_d   = '0;
          long_d  = 1'b1;
          state_d = ST_FETCH;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      long_q  <= 1'b0;
      hi_q    <= '0;
      exp_q   <= '0;
      rev_q   <= '0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      slong_q <= 1'b0;
      revo_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      long_q  <= long_d;
      done_q  <= done_d;
      valid_q <= valid_d;
      slong_q <= slong_d;
      revo_q  <= revo_d;
      if (state_q == ST_LOW) begin
        hi_q  <= hi_d;
        exp_q <= exp_d;
        rev_q <= rev_d;
      end
    end
  end

  assign done      = done_q;
  assign valid     = valid_q;
  assign size_long = slong_q;
  assign revision  = revo_q;

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr <= last_idx)); // R7
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !rd_en); // R7
  AST_RETRY_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FINAL && !crc_match) |-> ##1 (done || long_q)); // R5
  AST_FAIL_IS_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !valid) |-> size_long); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(start)) |-> $stable({valid, size_long, revision})); // R8
endmodule

// File: rtl/cfgprom_crc_chk.sv
module cfgprom_crc_chk
  import cfgprom_pkg::*;
#(
  parameter int SHORT_WORDS = 64,
  parameter int LONG_WORDS  = 220,
  parameter int ADDR_W      = $clog2(LONG_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [15:0]       rd_data,
  output logic              done,
  output logic              valid,
  output logic              size_long,
  output logic [7:0]        revision
);
  logic              rst_meta_q, rst_sync_q;
  logic              seed_en, feed_en;
  logic [BYTE_W-1:0] feed_byte;
  logic [BYTE_W-1:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  cfgprom_crc_reg u_crc (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .seed_en   (seed_en),
    .feed_en   (feed_en),
    .feed_byte (feed_byte),
    .crc_q     (crc_q)
  );

  cfgprom_seq #(
    .SHORT_WORDS (SHORT_WORDS),
    .LONG_WORDS  (LONG_WORDS),
    .ADDR_W      (ADDR_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .start     (start),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .crc_q     (crc_q),
    .seed_en   (seed_en),
    .feed_en   (feed_en),
    .feed_byte (feed_byte),
    .done      (done),
    .valid     (valid),
    .size_long (size_long),
    .revision  (revision)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_q |-> (!done && !valid && !size_long && !rd_en)); // R10
endmodule

// File: tb/cfgprom_crc_chk_bench.sv
module cfgprom_crc_chk_bench;
  localparam int SHORT_W = 64;
  localparam int LONG_W  = 220;
  localparam int AW      = $clog2(LONG_W);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [15:0]   rd_data;
  logic          done, valid, size_long;
  logic [7:0]    revision;

  logic [15:0] mem [0:LONG_W-1];
  int n_chk = 0;
  int n_bad = 0;
  int max_addr;
  int done_cnt;
  int cyc = 0;
  bit  finished = 0;

  always #10 clk = ~clk;

  cfgprom_crc_chk #(.SHORT_WORDS(SHORT_W), .LONG_WORDS(LONG_W)) u_cfgprom_crc_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .done(done), .valid(valid), .size_long(size_long),
    .revision(revision)
  );

  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[rd_addr];
      if (int'(rd_addr) > max_addr) max_addr = int'(rd_addr);
    end
    if (done) done_cnt++;
  end

  task automatic report_summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      report_summary();
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference byte update: shift in data LSB first, reflected constant 0xAB
  function automatic logic [7:0] upd(logic [7:0] c, logic [7:0] d);
    logic [7:0] r = c;
    for (int b = 0; b < 8; b++) begin
      logic fb = r[0] ^ d[b];
      r = r >> 1;
      if (fb) r = r ^ 8'hAB;
    end
    return r;
  endfunction

  function automatic logic [7:0] img_crc(int n);
    logic [7:0] c = 8'hFF;
    for (int w = 0; w < n - 1; w++) begin
      c = upd(c, mem[w][7:0]);
      c = upd(c, mem[w][15:8]);
    end
    c = upd(c, mem[n-1][7:0]);
    return c ^ 8'hFF;
  endfunction

  task automatic fill_random();
    for (int w = 0; w < LONG_W; w++) mem[w] = 16'($urandom);
  endtask

  // kind 0: short valid, 1: long valid, 2: both bad
  task automatic build(int kind, logic [7:0] rev);
    fill_random();
    if (kind == 0) begin
      mem[SHORT_W-1][7:0]  = rev;
      mem[SHORT_W-1][15:8] = img_crc(SHORT_W);
    end else begin
      if (mem[SHORT_W-1][15:8] == img_crc(SHORT_W)) mem[SHORT_W-1][15] = ~mem[SHORT_W-1][15];
      mem[LONG_W-1][7:0] = rev;
      mem[LONG_W-1][15:8] = img_crc(LONG_W) ^ ((kind == 2) ? 8'h01 : 8'h00);
    end
  endtask

  task automatic run(string tag, bit exp_v, bit exp_l, logic [7:0] exp_rev, bit stray);
    int waited = 0;
    max_addr = -1;
    done_cnt = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && waited < 3000) begin
      @(negedge clk);
      waited++;
      if (stray && waited == 20) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    chk({tag, " R8 done seen"}, int'(done), 1);
    chk({tag, " R4/R5/R6 valid"}, int'(valid), int'(exp_v));
    chk({tag, " R4/R5/R6 size_long"}, int'(size_long), int'(exp_l));
    chk({tag, " R3 revision"}, int'(revision), int'(exp_rev));
    chk({tag, " R7 last address read"}, max_addr, exp_l ? LONG_W - 1 : SHORT_W - 1);
    @(negedge clk);
    chk({tag, " R8 done single cycle"}, int'(done), 0);
    repeat (4) @(negedge clk);
    chk({tag, " R8 valid holds"}, int'(valid), int'(exp_v));
    chk({tag, " R8 revision holds"}, int'(revision), int'(exp_rev));
    chk({tag, " R9 one done per check"}, done_cnt, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    rd_data = '0;
    for (int w = 0; w < LONG_W; w++) mem[w] = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset done", int'(done), 0);
    chk("R10 reset valid", int'(valid), 0);
    chk("R10 reset rd_en", int'(rd_en), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 after release done", int'(done), 0);
    chk("R10 after release size_long", int'(size_long), 0);
    chk("R10 after release rd_en", int'(rd_en), 0);

    // R1 R2 R3 R4: short image accepted, edge revisions
    build(0, 8'h00); run("short rev00", 1, 0, 8'h00, 0);
    build(0, 8'hFF); run("short revFF", 1, 0, 8'hFF, 0);
    // R5: long image after short mismatch
    build(1, 8'h04); run("long rev04", 1, 1, 8'h04, 0);
    // R6: both mismatch
    build(2, 8'h5A); run("both bad", 0, 1, 8'h5A, 0);
    // R2: swapped byte order inside one word must break the short match
    build(0, 8'h21);
    mem[5] = {mem[5][7:0], mem[5][15:8]};
    if (mem[5][7:0] != mem[5][15:8]) begin
      mem[LONG_W-1][15:8] = ~img_crc(LONG_W);
      run("R2 swapped bytes", 0, 1, mem[LONG_W-1][7:0], 0);
    end
    // R3: stored CRC off by one bit fails the short attempt
    build(0, 8'h08);
    mem[SHORT_W-1][15:8] = mem[SHORT_W-1][15:8] ^ 8'h80;
    mem[LONG_W-1][15:8] = img_crc(LONG_W);
    run("R3 stored crc flip", 1, 1, mem[LONG_W-1][7:0], 0);
    // R9: stray start pulses mid-check
    build(0, 8'h33); run("R9 stray short", 1, 0, 8'h33, 1);
    build(1, 8'h44); run("R9 stray long", 1, 1, 8'h44, 1);
    // sweep over image kinds and revisions
    for (int t = 0; t < 24; t++) begin
      int k = t % 3;
      logic [7:0] r = 8'(t * 37 + 1);
      build(k, r);
      run("sweep R1", k != 2, k != 0, r, 0);
    end
    finished = 1;
    report_summary();
  end
endmodule